// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Datapath

This block is the arithmetic heart of an audio signal-processing core. Each clock it takes a signed data word and a signed coefficient, forms their full-precision product, and scales that product with a small set of fixed shift amounts. It then combines the result with one of several accumulator registers, or clears that accumulator. The accumulators are wider than the product, so a run of sums can overflow the product range without losing the sign. A separate read path picks any accumulator, scales it down by a selectable whole number of bytes and clamps it onto the narrower result bus. That bus feeds the rest of the core.

The controls are decoded fields that the surrounding sequencer presents every cycle: an operation code, a product-shift code, an accumulator index and a clear flag. The operands, the shifter and the ALU together form one registered stage, so the written accumulator shows its new value one clock after the operands. The read path is combinational from the accumulator registers.

Top module: `mac_datapath`

## Requirements
- R1: The product is the exact signed two's-complement product of the 24-bit `in_data` and the 16-bit `in_coef`, sign-extended to the 44-bit accumulator width.
- R2: `shift_sel` codes 1 to 7 shift the product arithmetically right by 1, 2, 4, 5, 8, 14 and 15 bits respectively.
- R3: `shift_sel` codes 8 to 13 shift the 44-bit sign-extended product left by 1, 2, 3, 4, 8 and 15 bits respectively. Bits above bit 43 are dropped.
- R4: `shift_sel` codes 0, 14 and 15 pass the product through unshifted.
- R5: With `op` = 2 (add), the accumulator chosen by `acc_sel` becomes its old value plus the shifted product, modulo 2^44, on the next rising clock edge. No other accumulator changes in that cycle.
- R6: With `op` = 3 (subtract), the chosen accumulator becomes its old value minus the shifted product, modulo 2^44.
- R7: With `op` = 1 (load), the chosen accumulator becomes the shifted product.
- R8: When `clr` is 1, the chosen accumulator becomes zero, whatever `op` and the operands are.
- R9: With `op` = 0 and `clr` = 0, no accumulator changes.
- R10: Codes 4 to 7 of `op` are 24-bit operations on bits 23:0 of the chosen accumulator and on `in_data`: add modulo 2^24 (4), AND (5), OR (6) and XOR (7). The 24-bit result is sign-extended to 44 bits and written back.
- R11: `bus_data` is accumulator `out_sel`, shifted arithmetically right by 8×`out_shift` bits. If that value lies outside the signed 28-bit range, `bus_data` shows 0x7FFFFFF or 0x8000000 according to its sign, and `bus_sat` is 1. Otherwise `bus_sat` is 0.
- R12: An active-low asynchronous reset clears all accumulators to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op | input | 3 | ALU operation code |
| shift_sel | input | 4 | Product shift code |
| acc_sel | input | 2 | Accumulator written this cycle |
| clr | input | 1 | Clear the chosen accumulator |
| in_data | input | 24 | Signed data operand |
| in_coef | input | 16 | Signed coefficient operand |
| out_sel | input | 2 | Accumulator driven onto the bus |
| out_shift | input | 2 | Bus scaling, in steps of 8 bits |
| bus_data | output | 28 | Scaled and clamped accumulator |
| bus_sat | output | 1 | Clamping occurred on the bus |

## Verification
The bench sweeps every operation against every shift code and drives operands at the extremes, including the most negative data times the most negative coefficient. A multiplier that lost the sign, or a shifter with a logical right shift or a wrong menu entry, would give wrong words at one of the four bus scalings. It forces 24-bit sums to wrap past the sign bit and lets left shifts and additions push values past the 28-bit bus range in both directions. A design that clamped on the wrong bits or failed to sign-extend would show a wrong value or a missing saturation flag. After every step all four accumulators are read back, so a write to the wrong index, or a write during a hold or a clear, shows up at once.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int SHSEL_W = 4;
    localparam int OSEL_W  = 2;

    typedef enum logic [2:0] {
        ALU_NOP   = 3'd0,
        ALU_LOAD  = 3'd1,
        ALU_ADD   = 3'd2,
        ALU_SUB   = 3'd3,
        ALU_ADD24 = 3'd4,
        ALU_AND24 = 3'd5,
        ALU_OR24  = 3'd6,
        ALU_XOR24 = 3'd7
    } alu_op_e;

endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
    parameter int A_W = 24,
    parameter int B_W = 16,
    parameter int P_W = A_W + B_W
) (
    input  logic [A_W-1:0] a,
    input  logic [B_W-1:0] b,
    output logic [P_W-1:0] p
);

    logic signed [P_W-1:0] a_ext;
    logic signed [P_W-1:0] b_ext;

    assign a_ext = {{(P_W-A_W){a[A_W-1]}}, a};
    assign b_ext = {{(P_W-B_W){b[B_W-1]}}, b};
    assign p     = a_ext * b_ext;

endmodule

// File: rtl/mac_shifter.sv
module mac_shifter
    import mac_pkg::*;
#(
    parameter int IN_W  = 40,
    parameter int OUT_W = 44
) (
    input  logic [IN_W-1:0]    din,
    input  logic [SHSEL_W-1:0] sel,
    output logic [OUT_W-1:0]   dout
);

    localparam logic [SHSEL_W-1:0] CODE_R1  = 4'd1;
    localparam logic [SHSEL_W-1:0] CODE_R2  = 4'd2;
    localparam logic [SHSEL_W-1:0] CODE_R4  = 4'd3;
    localparam logic [SHSEL_W-1:0] CODE_R5  = 4'd4;
    localparam logic [SHSEL_W-1:0] CODE_R8  = 4'd5;
    localparam logic [SHSEL_W-1:0] CODE_R14 = 4'd6;
    localparam logic [SHSEL_W-1:0] CODE_R15 = 4'd7;
    localparam logic [SHSEL_W-1:0] CODE_L1  = 4'd8;
    localparam logic [SHSEL_W-1:0] CODE_L2  = 4'd9;
    localparam logic [SHSEL_W-1:0] CODE_L3  = 4'd10;
    localparam logic [SHSEL_W-1:0] CODE_L4  = 4'd11;
    localparam logic [SHSEL_W-1:0] CODE_L8  = 4'd12;
    localparam logic [SHSEL_W-1:0] CODE_L15 = 4'd13;

    logic signed [OUT_W-1:0] ext;

    assign ext = {{(OUT_W-IN_W){din[IN_W-1]}}, din};

    always_comb begin
        case (sel)
            CODE_R1:  dout = ext >>> 1;
            CODE_R2:  dout = ext >>> 2;
            CODE_R4:  dout = ext >>> 4;
            CODE_R5:  dout = ext >>> 5;
            CODE_R8:  dout = ext >>> 8;
            CODE_R14: dout = ext >>> 14;
            CODE_R15: dout = ext >>> 15;
            CODE_L1:  dout = ext << 1;
            CODE_L2:  dout = ext << 2;
            CODE_L3:  dout = ext << 3;
            CODE_L4:  dout = ext << 4;
            CODE_L8:  dout = ext << 8;
            CODE_L15: dout = ext << 15;
            default:  dout = ext;
        endcase
    end

endmodule

// File: rtl/mac_alu.sv
module mac_alu
    import mac_pkg::*;
#(
    parameter int ACC_W  = 44,
    parameter int DATA_W = 24
) (
    input  alu_op_e          op,
    input  logic             clr,
    input  logic [ACC_W-1:0] acc_old,
    input  logic [ACC_W-1:0] addend,
    input  logic [DATA_W-1:0] data,
    output logic [ACC_W-1:0] acc_new,
    output logic             we
);

    localparam int EXT_W = ACC_W - DATA_W;

    logic [DATA_W-1:0] low_old;
    logic [DATA_W-1:0] narrow;

    assign low_old = acc_old[DATA_W-1:0];

    always_comb begin
        narrow = '0;
        unique case (op)
            ALU_ADD24: narrow = low_old + data;
            ALU_AND24: narrow = low_old & data;
            ALU_OR24:  narrow = low_old | data;
            ALU_XOR24: narrow = low_old ^ data;
            ALU_NOP, ALU_LOAD, ALU_ADD, ALU_SUB: narrow = '0;
        endcase
    end

    always_comb begin
        acc_new = acc_old;
        unique case (op)
            ALU_NOP:  acc_new = acc_old;
            ALU_LOAD: acc_new = addend;
            ALU_ADD:  acc_new = acc_old + addend;
            ALU_SUB:  acc_new = acc_old - addend;
            ALU_ADD24, ALU_AND24, ALU_OR24, ALU_XOR24:
                      acc_new = {{EXT_W{narrow[DATA_W-1]}}, narrow};
        endcase
        if (clr) begin
            acc_new = '0;
        end
    end

    assign we = clr || (op != ALU_NOP);

endmodule

// File: rtl/mac_acc_bank.sv
module mac_acc_bank #(
    parameter int N     = 4,
    parameter int W     = 44,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] wsel,
    input  logic [W-1:0]     wdata,
    output logic [N*W-1:0]   q_flat
);

    for (genvar g = 0; g < N; g++) begin : g_acc
        logic [W-1:0] q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (we && (wsel == IDX_W'(g))) begin
                q <= wdata;
            end
        end

        assign q_flat[g*W +: W] = q;
    end

endmodule

// File: rtl/mac_bus_sat.sv
module mac_bus_sat
    import mac_pkg::*;
#(
    parameter int ACC_W    = 44,
    parameter int BUS_W    = 28,
    parameter int OUT_STEP = 8
) (
    input  logic [ACC_W-1:0]  acc,
    input  logic [OSEL_W-1:0] osel,
    output logic [BUS_W-1:0]  bus,
    output logic              sat
);

    localparam int HI_W = ACC_W - BUS_W + 1;
    localparam logic [BUS_W-1:0] POS_LIM = {1'b0, {(BUS_W-1){1'b1}}};
    localparam logic [BUS_W-1:0] NEG_LIM = {1'b1, {(BUS_W-1){1'b0}}};

    logic signed [ACC_W-1:0] scaled;
    logic [HI_W-1:0]         hi_bits;

    assign scaled  = $signed(acc) >>> (int'(osel) * OUT_STEP);
    assign hi_bits = scaled[ACC_W-1:BUS_W-1];
    assign sat     = !((&hi_bits) || !(|hi_bits));

    always_comb begin
        if (!sat) begin
            bus = scaled[BUS_W-1:0];
        end else if (scaled[ACC_W-1]) begin
            bus = NEG_LIM;
        end else begin
            bus = POS_LIM;
        end
    end

endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
    import mac_pkg::*;
#(
    parameter int DATA_W    = 24,
    parameter int COEF_W    = 16,
    parameter int GUARD_W   = 4,
    parameter int BUS_W     = 28,
    parameter int NUM_ACC   = 4,
    parameter int OUT_STEP  = 8,
    parameter int ACC_SEL_W = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           op,
    input  logic [SHSEL_W-1:0]   shift_sel,
    input  logic [ACC_SEL_W-1:0] acc_sel,
    input  logic                 clr,
    input  logic [DATA_W-1:0]    in_data,
    input  logic [COEF_W-1:0]    in_coef,
    input  logic [ACC_SEL_W-1:0] out_sel,
    input  logic [OSEL_W-1:0]    out_shift,
    output logic [BUS_W-1:0]     bus_data,
    output logic                 bus_sat
);

    localparam int PROD_W = DATA_W + COEF_W;
    localparam int ACC_W  = PROD_W + GUARD_W;

    alu_op_e              op_e;
    logic [PROD_W-1:0]    product;
    logic [ACC_W-1:0]     scaled_prod;
    logic [ACC_W-1:0]     acc_cur;
    logic [ACC_W-1:0]     acc_next;
    logic                 acc_we;
    logic [NUM_ACC*ACC_W-1:0] acc_flat;
    logic [ACC_W-1:0]     acc_rd;

    assign op_e = alu_op_e'(op);

    mac_mult #(
        .A_W (DATA_W),
        .B_W (COEF_W),
        .P_W (PROD_W)
    ) u_mult (
        .a (in_data),
        .b (in_coef),
        .p (product)
    );

    mac_shifter #(
        .IN_W  (PROD_W),
        .OUT_W (ACC_W)
    ) u_shift (
        .din  (product),
        .sel  (shift_sel),
        .dout (scaled_prod)
    );

    assign acc_cur = acc_flat[acc_sel*ACC_W +: ACC_W];

    mac_alu #(
        .ACC_W  (ACC_W),
        .DATA_W (DATA_W)
    ) u_alu (
        .op      (op_e),
        .clr     (clr),
        .acc_old (acc_cur),
        .addend  (scaled_prod),
        .data    (in_data),
        .acc_new (acc_next),
        .we      (acc_we)
    );

    mac_acc_bank #(
        .N     (NUM_ACC),
        .W     (ACC_W),
        .IDX_W (ACC_SEL_W)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (acc_we),
        .wsel   (acc_sel),
        .wdata  (acc_next),
        .q_flat (acc_flat)
    );

    assign acc_rd = acc_flat[out_sel*ACC_W +: ACC_W];

    mac_bus_sat #(
        .ACC_W    (ACC_W),
        .BUS_W    (BUS_W),
        .OUT_STEP (OUT_STEP)
    ) u_sat (
        .acc  (acc_rd),
        .osel (out_shift),
        .bus  (bus_data),
        .sat  (bus_sat)
    );

endmodule

// File: rtl/mac_datapath_chk.sv
module mac_datapath_chk #(
    parameter int DATA_W    = 24,
    parameter int COEF_W    = 16,
    parameter int GUARD_W   = 4,
    parameter int BUS_W     = 28,
    parameter int NUM_ACC   = 4,
    parameter int ACC_SEL_W = 2
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic [2:0]                        op,
    input logic [3:0]                        shift_sel,
    input logic [ACC_SEL_W-1:0]              acc_sel,
    input logic                              clr,
    input logic [DATA_W-1:0]                 in_data,
    input logic [COEF_W-1:0]                 in_coef,
    input logic [NUM_ACC*(DATA_W+COEF_W+GUARD_W)-1:0] acc_flat,
    input logic [BUS_W-1:0]                  bus_data,
    input logic                              bus_sat
);

    localparam int ACC_W = DATA_W + COEF_W + GUARD_W;
    localparam logic [BUS_W-1:0] POS_LIM = {1'b0, {(BUS_W-1){1'b1}}};
    localparam logic [BUS_W-1:0] NEG_LIM = {1'b1, {(BUS_W-1){1'b0}}};

    logic [NUM_ACC*ACC_W-1:0] prev_flat;
    logic [ACC_SEL_W-1:0]     idx_q;
    logic                     clr_q;
    logic                     nop_q;
    logic                     load_q;
    logic signed [ACC_W-1:0]  prod_q;
    logic signed [ACC_W-1:0]  d_ext;
    logic signed [ACC_W-1:0]  c_ext;
    logic [NUM_ACC-1:0]       chg;
    logic [ACC_W-1:0]         word_q;

    assign d_ext = {{(ACC_W-DATA_W){in_data[DATA_W-1]}}, in_data};
    assign c_ext = {{(ACC_W-COEF_W){in_coef[COEF_W-1]}}, in_coef};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_flat <= '0;
            idx_q     <= '0;
            clr_q     <= 1'b0;
            nop_q     <= 1'b0;
            load_q    <= 1'b0;
            prod_q    <= '0;
        end else begin
            prev_flat <= acc_flat;
            idx_q     <= acc_sel;
            clr_q     <= clr;
            nop_q     <= (op == 3'd0) && !clr;
            load_q    <= (op == 3'd1) && !clr && (shift_sel == 4'd0);
            prod_q    <= d_ext * c_ext;
        end
    end

    for (genvar g = 0; g < NUM_ACC; g++) begin : g_chg
        assign chg[g] = acc_flat[g*ACC_W +: ACC_W] != prev_flat[g*ACC_W +: ACC_W];
    end

    assign word_q = acc_flat[idx_q*ACC_W +: ACC_W];

    // R8
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_q |-> (word_q == '0));

    // R5
    one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chg));

    // R9
    nop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nop_q |-> (chg == '0));

    // R7
    load_prod_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_q |-> (word_q == prod_q));

    // R11
    sat_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sat |-> ((bus_data == POS_LIM) || (bus_data == NEG_LIM)));

endmodule

bind mac_datapath mac_datapath_chk #(
    .DATA_W    (DATA_W),
    .COEF_W    (COEF_W),
    .GUARD_W   (GUARD_W),
    .BUS_W     (BUS_W),
    .NUM_ACC   (NUM_ACC),
    .ACC_SEL_W (ACC_SEL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .shift_sel (shift_sel),
    .acc_sel   (acc_sel),
    .clr       (clr),
    .in_data   (in_data),
    .in_coef   (in_coef),
    .acc_flat  (acc_flat),
    .bus_data  (bus_data),
    .bus_sat   (bus_sat)
);

// File: tb/mac_datapath_tb.sv
module mac_datapath_tb;

    localparam int DW = 24;
    localparam int CW = 16;
    localparam int AW = 44;
    localparam int BW = 28;
    localparam int NA = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    op = '0;
    logic [3:0]    shift_sel = '0;
    logic [1:0]    acc_sel = '0;
    logic          clr = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic [CW-1:0] in_coef = '0;
    logic [1:0]    out_sel = '0;
    logic [1:0]    out_shift = '0;
    logic [BW-1:0] bus_data;
    logic          bus_sat;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic signed [AW-1:0] model [NA];

    always #10 clk = ~clk;

    mac_datapath u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .shift_sel (shift_sel),
        .acc_sel   (acc_sel),
        .clr       (clr),
        .in_data   (in_data),
        .in_coef   (in_coef),
        .out_sel   (out_sel),
        .out_shift (out_shift),
        .bus_data  (bus_data),
        .bus_sat   (bus_sat)
    );

    function automatic logic signed [AW-1:0] shifted_prod(int d, int c, int code);
        logic signed [AW-1:0] p;
        int rs [7] = '{1, 2, 4, 5, 8, 14, 15};
        int ls [6] = '{1, 2, 3, 4, 8, 15};
        p = AW'(d);
        p = p * AW'(c);
        if (code >= 1 && code <= 7) return p >>> rs[code-1];
        if (code >= 8 && code <= 13) return p << ls[code-8];
        return p;
    endfunction

    function automatic logic signed [AW-1:0] next_val(int o, bit cl,
        logic signed [AW-1:0] old, int d, int c, int code);
        logic [DW-1:0] lo;
        logic [DW-1:0] dd;
        logic [DW-1:0] r;
        logic signed [AW-1:0] s;
        lo = old[DW-1:0];
        dd = DW'(d);
        s  = shifted_prod(d, c, code);
        if (cl) return '0;
        case (o)
            0: return old;
            1: return s;
            2: return old + s;
            3: return old - s;
            4: r = lo + dd;
            5: r = lo & dd;
            6: r = lo | dd;
            default: r = lo ^ dd;
        endcase
        return {{(AW-DW){r[DW-1]}}, r};
    endfunction

    task automatic verify(string tag);
        logic signed [AW-1:0] v;
        logic [BW-1:0] eb;
        bit es;
        for (int i = 0; i < NA; i++) begin
            for (int k = 0; k < 4; k++) begin
                out_sel = 2'(i);
                out_shift = 2'(k);
                #1;
                v = model[i] >>> (8 * k);
                if (v > 44'sd134217727) begin
                    eb = {1'b0, {(BW-1){1'b1}}}; es = 1'b1;
                end else if (v < -44'sd134217728) begin
                    eb = {1'b1, {(BW-1){1'b0}}}; es = 1'b1;
                end else begin
                    eb = v[BW-1:0]; es = 1'b0;
                end
                checks++;
                if (bus_data !== eb || bus_sat !== es) begin
                    errors++;
                    $display("FAIL %s acc%0d scale%0d: got %h sat %b expected %h sat %b",
                             tag, i, k, bus_data, bus_sat, eb, es);
                end
            end
        end
    endtask

    task automatic step(int o, int code, int sel, bit cl, int d, int c, string tag);
        @(negedge clk);
        op = 3'(o); shift_sel = 4'(code); acc_sel = 2'(sel); clr = cl;
        in_data = DW'(d); in_coef = CW'(c);
        @(posedge clk);
        model[sel] = next_val(o, cl, model[sel], d, c, code);
        @(negedge clk);
        op = '0; clr = 1'b0;
        verify(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired (all requirements)");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int dl [6] = '{-8388608, -1, 0, 1, 8388607, 3515843};
        int cf [6] = '{-32768, -1, 0, 1, 32767, 4660};
        for (int i = 0; i < NA; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        verify("R12 reset clears all accumulators");

        // R1 product over operand extremes
        for (int a = 0; a < 6; a++)
            for (int b = 0; b < 6; b++)
                step(1, 0, (a + b) % NA, 1'b0, dl[a], cf[b], "R1 R7 signed product load");

        // R2 / R3 / R4 shift menu, loaded then accumulated
        for (int code = 0; code < 16; code++) begin
            step(1, code, code % NA, 1'b0, 5592405, -12345,
                 code < 8 ? "R2 R4 right shift load" : "R3 R4 left shift load");
            step(2, code, code % NA, 1'b0, -8388608, 32767,
                 code < 8 ? "R2 R5 right shift accumulate" : "R3 R5 left shift accumulate");
            step(3, code, (code + 1) % NA, 1'b0, 1234567, -32768,
                 "R4 R6 shifted subtract");
        end

        // R5 R6 R7 R10: every operation against every shift code
        for (int o = 0; o < 8; o++)
            for (int code = 0; code < 16; code++)
                step(o, code, (o + code) % NA, 1'b0, 7654321 - o * 999, 20000 - code * 3001,
                     "R5 R6 R7 R10 op sweep");

        // R8 clear overrides any operation
        for (int o = 0; o < 8; o++)
            step(o, 9, o % NA, 1'b1, 8388607, 32767, "R8 clear wins");

        // R9 hold with live operands
        step(1, 0, 2, 1'b0, 4000000, 30000, "R7 preload");
        for (int s = 0; s < NA; s++)
            step(0, 13, s, 1'b0, -8388608, -32768, "R9 nop holds");

        // R10 24-bit wrap into the sign bit
        step(8 - 8, 0, 1, 1'b1, 0, 0, "R8 clear before wrap");
        step(4, 0, 1, 1'b0, 8388607, 0, "R10 add24 to max");
        step(4, 0, 1, 1'b0, 1, 0, "R10 add24 wraps negative");
        step(7, 0, 1, 1'b0, -1, 0, "R10 xor24 invert");
        step(5, 0, 1, 1'b0, 15790320, 0, "R10 and24 mask");
        step(6, 0, 1, 1'b0, 3355443, 0, "R10 or24 merge");

        // R11 saturation both directions and guard-bit growth
        step(1, 13, 0, 1'b0, 8388607, 32767, "R11 large positive");
        step(1, 13, 3, 1'b0, -8388608, 32767, "R11 large negative");
        for (int r = 0; r < 10; r++)
            step(2, 0, 2, 1'b0, -8388608, -32768, "R11 R5 guard bit growth");
        step(1, 8, 1, 1'b0, 65536, 1024, "R11 boundary just above");
        step(1, 0, 1, 1'b0, 8191, 16383, "R11 boundary inside");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule